// File: doc/BRIEF.md
# Automatic Baud-Rate Break/Synch Detector

This block sits beside a serial data receiver and watches the receive line for a LIN-style header: a long low break, a high delimiter, then the synch character 0x55. It checks the break length against the current bit-time estimate and checks the delimiter against a programmed minimum. It then times the synch character in reference ticks and publishes a new per-bit divisor. Errors are reported as single-cycle pulses: a break that stays low too long, and a synch field too slow for the timing counter. A successful header gives one frame-valid pulse together with the divisor update.

The block also decides when the receive-ready indication fires. When dormant operation is combined with automatic detection, only a complete, valid header wakes the host. Characters from the data receiver and bare breaks are then suppressed. In normal operation, receive-ready follows the data receiver's character strobe, and a break can raise it when break notification is enabled.

Time is measured in reference ticks. The `tick` input is a clock enable, and `bit_div` gives the number of ticks in one bit at the current rate. The line input is asynchronous and passes through a synchronizer inside the block.

Top module: `autobaud_detect`

## Requirements
- R1: While `auto_en` is 0 the detector measures nothing. `brk_det`, `brk_tmo`, `syn_tmo`, `frame_ok` and `div_upd_valid` stay 0, and `rx_ready` follows `rx_char_done` one cycle later.
- R2: A low level of at least 11 bit times (`11*bit_div` ticks) that then returns high gives exactly one `brk_det` pulse. A shorter low gives none.
- R3: A low level lasting longer than 22 bit times gives one `brk_tmo` pulse and no `brk_det`. The detector then waits for the line to go high and produces no divisor update from that low.
- R4: The minimum delimiter is set by `delim_sel`: 0 means 1 bit time, 1 means 2, 2 means 3 and 3 means 4 bit times. If the line falls before the minimum has elapsed, the sequence is abandoned without an update.
- R5: After a valid break and delimiter, the detector counts ticks from the synch field's first falling edge to its fifth falling edge, which spans 8 bits of 0x55 sent LSB first. It outputs that count shifted right by 3 on `div_upd`, with one-cycle `div_upd_valid` and `frame_ok` pulses.
- R6: If the synch count would pass 2^(DIV_W+3)-1 ticks before the fifth falling edge, one `syn_tmo` pulse is given and no update.
- R7: With `dormant` and `auto_en` both 1, `rx_ready` pulses only for `frame_ok`. `rx_char_done` and breaks do not raise it.
- R8: With dormant gating off, `rx_ready` pulses for each `rx_char_done`, and for each `brk_det` only when `brk_irq_en` is 1.
- R9: `div_upd` resets to 0 and changes only in a cycle where `div_upd_valid` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rxd | input | 1 | Asynchronous receive line, idle high |
| tick | input | 1 | Reference tick enable for all measurements |
| bit_div | input | DIV_W | Current bit time in ticks |
| auto_en | input | 1 | Enables break/synch measurement |
| delim_sel | input | 2 | Minimum delimiter length code |
| dormant | input | 1 | Dormant (wake-on-header) operation |
| brk_irq_en | input | 1 | Lets a detected break raise rx_ready |
| rx_char_done | input | 1 | Character strobe from the data receiver |
| div_upd | output | DIV_W | Last measured per-bit divisor |
| div_upd_valid | output | 1 | Pulse: div_upd has just been updated |
| brk_det | output | 1 | Pulse: valid break seen |
| brk_tmo | output | 1 | Pulse: break exceeded 22 bit times |
| syn_tmo | output | 1 | Pulse: synch field exceeded counter range |
| frame_ok | output | 1 | Pulse: complete header accepted |
| rx_ready | output | 1 | Pulse: gated receive-ready indication |

## Verification
The synch-timeout path is the hardest case to reach from the ports. The synch field must be slow enough to saturate an (DIV_W+3)-bit tick counter. Yet each of its low bits must stay shorter than a break at the current rate, or the trailing data bits are taken as a fresh break. The stimulus therefore raises `bit_div` for that scenario only, sends a break long enough for the new rate, and then sends 0x55 at 260 ticks per bit. The delimiter-abort case is reached the same way, with a programmed minimum larger than the delimiter actually driven.

// File: rtl/abd_pkg.sv
package abd_pkg;
    timeunit 1ns;
    timeprecision 1ps;

    // Detector sequence states
    typedef enum logic [2:0] {
        ST_IDLE,     // line high, searching for a low
        ST_BREAK,    // timing a low level
        ST_DELIM,    // timing the high after a break
        ST_SYNC,     // counting falling edges of the synch character
        ST_WAIT_HI   // parked until the line returns high
    } abd_state_e;

endpackage

// File: rtl/abd_line_sync.sv
module abd_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd,
    output logic lvl,
    output logic fall
);
    timeunit 1ns;
    timeprecision 1ps;

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t sy_d, sy_q;

    always_comb begin
        sy_d = sy_q;
        sy_d.chain[0] = rxd;
        for (int i = 1; i < STAGES; i++) begin
            sy_d.chain[i] = sy_q.chain[i-1];
        end
        sy_d.prev = sy_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign lvl  = sy_q.chain[STAGES-1];
    assign fall = sy_q.prev & ~sy_q.chain[STAGES-1];

endmodule

// File: rtl/abd_limits.sv
module abd_limits #(
    parameter int DIV_W    = 8,
    parameter int MIN_BITS = 11,
    parameter int MAX_BITS = 22,
    parameter int BW       = DIV_W + 5,
    parameter int DW       = DIV_W + 2
) (
    input  logic [DIV_W-1:0] bit_div,
    input  logic [1:0]       delim_sel,
    output logic [BW-1:0]    brk_min,
    output logic [BW-1:0]    brk_max,
    output logic [DW-1:0]    delim_need
);
    timeunit 1ns;
    timeprecision 1ps;

    // Thresholds in ticks, scaled from the current bit time
    always_comb begin
        brk_min    = BW'(bit_div) * BW'(MIN_BITS);
        brk_max    = BW'(bit_div) * BW'(MAX_BITS);
        delim_need = DW'(bit_div) * (DW'(delim_sel) + DW'(1));
    end

endmodule

// File: rtl/autobaud_detect.sv
module autobaud_detect #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int BRK_MIN_BT  = 11,
    parameter int BRK_MAX_BT  = 22
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rxd,
    input  logic             tick,
    input  logic [DIV_W-1:0] bit_div,
    input  logic             auto_en,
    input  logic [1:0]       delim_sel,
    input  logic             dormant,
    input  logic             brk_irq_en,
    input  logic             rx_char_done,
    output logic [DIV_W-1:0] div_upd,
    output logic             div_upd_valid,
    output logic             brk_det,
    output logic             brk_tmo,
    output logic             syn_tmo,
    output logic             frame_ok,
    output logic             rx_ready
);
    timeunit 1ns;
    timeprecision 1ps;
    import abd_pkg::*;

    // 0x55 sent LSB first: five falling edges span eight bit times
    localparam int SYNC_EDGES = 5;
    localparam int SPAN_LOG2  = 3;
    localparam int BW = DIV_W + $clog2(BRK_MAX_BT + 1);
    localparam int DW = DIV_W + 2;
    localparam int SW = DIV_W + SPAN_LOG2;
    localparam int FW = $clog2(SYNC_EDGES + 1);

    typedef struct packed {
        abd_state_e       st;
        logic [BW-1:0]    lcnt;
        logic [DW-1:0]    dcnt;
        logic [SW-1:0]    scnt;
        logic [FW-1:0]    fcnt;
        logic [DIV_W-1:0] div;
        logic             div_vld;
        logic             brk;
        logic             btmo;
        logic             stmo;
        logic             fok;
        logic             rdy;
    } abd_regs_t;

    abd_regs_t rg_d, rg_q;

    logic          lvl, fall;
    logic [BW-1:0] brk_min, brk_max;
    logic [DW-1:0] delim_need;
    logic [SW:0]   span_sum;
    logic          gate;

    abd_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .rxd  (rxd),
        .lvl  (lvl),
        .fall (fall)
    );

    abd_limits #(
        .DIV_W   (DIV_W),
        .MIN_BITS(BRK_MIN_BT),
        .MAX_BITS(BRK_MAX_BT),
        .BW      (BW),
        .DW      (DW)
    ) u_lim (
        .bit_div   (bit_div),
        .delim_sel (delim_sel),
        .brk_min   (brk_min),
        .brk_max   (brk_max),
        .delim_need(delim_need)
    );

    assign gate     = dormant & auto_en;
    assign span_sum = {1'b0, rg_q.scnt} + (SW+1)'(tick);

    always_comb begin
        rg_d         = rg_q;
        rg_d.div_vld = 1'b0;
        rg_d.brk     = 1'b0;
        rg_d.btmo    = 1'b0;
        rg_d.stmo    = 1'b0;
        rg_d.fok     = 1'b0;

        if (!auto_en) begin
            rg_d.st = ST_IDLE;
        end else begin
            unique case (rg_q.st)
                ST_IDLE: begin
                    if (!lvl) begin
                        rg_d.st   = ST_BREAK;
                        rg_d.lcnt = '0;
                    end
                end
                ST_BREAK: begin
                    if (lvl) begin
                        if (rg_q.lcnt >= brk_min) begin
                            rg_d.brk  = 1'b1;
                            rg_d.st   = ST_DELIM;
                            rg_d.dcnt = '0;
                        end else begin
                            rg_d.st = ST_IDLE;
                        end
                    end else if (rg_q.lcnt > brk_max) begin
                        rg_d.btmo = 1'b1;
                        rg_d.st   = ST_WAIT_HI;
                    end else if (tick) begin
                        rg_d.lcnt = rg_q.lcnt + BW'(1);
                    end
                end
                ST_DELIM: begin
                    if (fall) begin
                        if (rg_q.dcnt >= delim_need) begin
                            rg_d.st   = ST_SYNC;
                            rg_d.scnt = '0;
                            rg_d.fcnt = FW'(1);
                        end else begin
                            rg_d.st = ST_IDLE;
                        end
                    end else if (tick && (rg_q.dcnt != '1)) begin
                        rg_d.dcnt = rg_q.dcnt + DW'(1);
                    end
                end
                ST_SYNC: begin
                    if (tick && (rg_q.scnt == '1)) begin
                        rg_d.stmo = 1'b1;
                        rg_d.st   = ST_WAIT_HI;
                    end else if (fall && (rg_q.fcnt == FW'(SYNC_EDGES - 1))) begin
                        rg_d.div     = span_sum[SPAN_LOG2 +: DIV_W];
                        rg_d.div_vld = 1'b1;
                        rg_d.fok     = 1'b1;
                        rg_d.st      = ST_WAIT_HI;
                    end else begin
                        rg_d.scnt = span_sum[SW-1:0];
                        if (fall) begin
                            rg_d.fcnt = rg_q.fcnt + FW'(1);
                        end
                    end
                end
                ST_WAIT_HI: begin
                    if (lvl) begin
                        rg_d.st = ST_IDLE;
                    end
                end
                default: rg_d.st = ST_IDLE;
            endcase
        end

        // Receive-ready gating
        if (gate) begin
            rg_d.rdy = rg_d.fok;
        end else begin
            rg_d.rdy = rx_char_done | (rg_d.brk & brk_irq_en);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q    <= '0;
            rg_q.st <= ST_IDLE;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign div_upd       = rg_q.div;
    assign div_upd_valid = rg_q.div_vld;
    assign brk_det       = rg_q.brk;
    assign brk_tmo       = rg_q.btmo;
    assign syn_tmo       = rg_q.stmo;
    assign frame_ok      = rg_q.fok;
    assign rx_ready      = rg_q.rdy;

    AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(auto_en) |-> !(brk_det || brk_tmo || syn_tmo || frame_ok || div_upd_valid)); // R1

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({brk_det, brk_tmo, syn_tmo, frame_ok})); // R3

    AST_FRAME_UPDATES: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |-> div_upd_valid); // R5

    AST_DORMANT_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dormant && auto_en) && rx_ready) |-> frame_ok); // R7

    AST_DIV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !div_upd_valid |-> $stable(div_upd)); // R9

endmodule

// File: tb/autobaud_detect_bench.sv
module autobaud_detect_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DIV_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             rxd = 1'b1;
    logic             tick = 1'b1;
    logic [DIV_W-1:0] bit_div = 8'd16;
    logic             auto_en = 1'b0;
    logic [1:0]       delim_sel = 2'd0;
    logic             dormant = 1'b0;
    logic             brk_irq_en = 1'b0;
    logic             rx_char_done = 1'b0;
    logic [DIV_W-1:0] div_upd;
    logic             div_upd_valid, brk_det, brk_tmo, syn_tmo, frame_ok, rx_ready;

    int n_chk = 0;
    int n_bad = 0;
    int c_brk = 0, c_btmo = 0, c_stmo = 0, c_fok = 0, c_upd = 0, c_rdy = 0;
    int last_div = 0;
    int s_brk, s_btmo, s_stmo, s_fok, s_upd, s_rdy;

    always #2.5 clk = ~clk;

    autobaud_detect #(.DIV_W(DIV_W)) u_autobaud_detect (
        .clk          (clk),
        .rst_n        (rst_n),
        .rxd          (rxd),
        .tick         (tick),
        .bit_div      (bit_div),
        .auto_en      (auto_en),
        .delim_sel    (delim_sel),
        .dormant      (dormant),
        .brk_irq_en   (brk_irq_en),
        .rx_char_done (rx_char_done),
        .div_upd      (div_upd),
        .div_upd_valid(div_upd_valid),
        .brk_det      (brk_det),
        .brk_tmo      (brk_tmo),
        .syn_tmo      (syn_tmo),
        .frame_ok     (frame_ok),
        .rx_ready     (rx_ready)
    );

    // Pulse counters observed at the ports
    always @(posedge clk) begin
        if (rst_n) begin
            if (brk_det)       c_brk++;
            if (brk_tmo)       c_btmo++;
            if (syn_tmo)       c_stmo++;
            if (frame_ok)      c_fok++;
            if (rx_ready)      c_rdy++;
            if (div_upd_valid) begin
                c_upd++;
                last_div = int'(div_upd);
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic snap();
        s_brk = c_brk; s_btmo = c_btmo; s_stmo = c_stmo;
        s_fok = c_fok; s_upd = c_upd;   s_rdy = c_rdy;
    endtask

    task automatic drive(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_55(input int per);
        drive(1'b0, per);
        for (int i = 0; i < 8; i++) begin
            drive((i % 2 == 0) ? 1'b1 : 1'b0, per);
        end
        drive(1'b1, per);
    endtask

    task automatic header(input int low, input int hi, input int per);
        drive(1'b0, low);
        drive(1'b1, hi);
        send_55(per);
        drive(1'b1, 40);
    endtask

    task automatic char_pulse();
        rx_char_done = 1'b1;
        @(negedge clk);
        rx_char_done = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R9 reset div_upd", int'(div_upd), 0);
        chk("R1 reset flags", int'({brk_det, brk_tmo, syn_tmo, frame_ok, div_upd_valid, rx_ready}), 0);
    endtask

    task automatic t_disabled();
        auto_en = 1'b0;
        snap();
        header(200, 20, 20);
        chk("R1 disabled no events", (c_brk - s_brk) + (c_btmo - s_btmo) + (c_stmo - s_stmo) + (c_fok - s_fok), 0);
        chk("R1 disabled no update", c_upd - s_upd, 0);
        snap();
        char_pulse();
        chk("R1 disabled rx_ready follows char", c_rdy - s_rdy, 1);
    endtask

    task automatic t_short_low();
        auto_en = 1'b1;
        snap();
        drive(1'b0, 100);
        drive(1'b1, 50);
        chk("R2 short low no break", c_brk - s_brk, 0);
    endtask

    task automatic t_frame();
        delim_sel = 2'd0;
        snap();
        header(200, 20, 20);
        chk("R2 break detected once", c_brk - s_brk, 1);
        chk("R5 one frame_ok", c_fok - s_fok, 1);
        chk("R5 one update", c_upd - s_upd, 1);
        chk("R5 divisor 20", last_div, 20);
        chk("R9 div_upd holds 20", int'(div_upd), 20);
    endtask

    task automatic t_break_timeout();
        snap();
        drive(1'b0, 400);
        drive(1'b1, 50);
        chk("R3 one break timeout", c_btmo - s_btmo, 1);
        chk("R3 no break on timeout", c_brk - s_brk, 0);
        chk("R3 no update on timeout", c_upd - s_upd, 0);
    endtask

    task automatic t_delim();
        delim_sel = 2'd3;
        snap();
        header(200, 32, 16);
        chk("R4 short delimiter no update", c_upd - s_upd, 0);
        chk("R4 break still flagged", c_brk - s_brk, 1);
        chk("R9 div_upd kept after abort", int'(div_upd), 20);
        snap();
        header(200, 80, 16);
        chk("R4 long delimiter accepted", c_upd - s_upd, 1);
        chk("R5 divisor 16", last_div, 16);
        delim_sel = 2'd0;
    endtask

    task automatic t_sync_timeout();
        bit_div = 8'd32;
        snap();
        header(400, 40, 260);
        chk("R6 one synch timeout", c_stmo - s_stmo, 1);
        chk("R6 no update on synch timeout", c_upd - s_upd, 0);
        chk("R9 div_upd kept after timeout", int'(div_upd), 16);
        bit_div = 8'd16;
    endtask

    task automatic t_dormant();
        dormant = 1'b1;
        brk_irq_en = 1'b1;
        snap();
        char_pulse();
        chk("R7 char ignored when dormant", c_rdy - s_rdy, 0);
        snap();
        header(200, 20, 24);
        chk("R7 ready only on header", c_rdy - s_rdy, 1);
        chk("R7 header accepted", c_fok - s_fok, 1);
        chk("R5 divisor 24", last_div, 24);
        dormant = 1'b0;
    endtask

    task automatic t_break_irq();
        brk_irq_en = 1'b1;
        snap();
        header(200, 20, 20);
        chk("R8 break raises ready", c_rdy - s_rdy, 1);
        snap();
        char_pulse();
        chk("R8 char raises ready", c_rdy - s_rdy, 1);
        brk_irq_en = 1'b0;
        snap();
        header(200, 20, 20);
        chk("R8 break masked", c_rdy - s_rdy, 0);
        chk("R8 break still flagged", c_brk - s_brk, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_disabled();
        t_short_low();
        t_frame();
        t_break_timeout();
        t_delim();
        t_sync_timeout();
        t_dormant();
        t_break_irq();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule